// File: doc/BRIEF.md
# Lamp Protection and Striking Sequencer

This block is the digital mode and fault controller of a cold-cathode lamp inverter. Analog comparators outside the block turn the lamp feedback, the control voltage, the die temperature and the supply and enable levels into single-bit flags. The block uses those flags to power up into a striking phase. During striking it looks for ignition. Once the lamp has ignited it runs in normal mode. In normal mode a digital delay timer integrates fault conditions, and when it crosses a limit the block moves to a latched shutdown state.

The striking phase has a fixed time budget of several timer ramps at the slow rate. The first ramp starts from zero and every later ramp starts from a restart level. If the lamp has not ignited when the last ramp ends, the block shuts down. In normal mode, open-lamp and control-voltage-high faults charge the timer at the slow rate, and short-lamp and over-voltage faults charge it at a faster rate. A contrast-boost input stops open-lamp and short-lamp faults from causing shutdown. Over-temperature trips the block at once. A shutdown stays latched until the supply flag or the enable flag drops.

Top module: `lamp_prot_seq`

## Requirements
- R1: While `supply_ok` or `enable` is low, the block is idle: `striking`, `running` and `latched_off` are 0 and `timer_val` is 0, from the first edge after the condition.
- R2: When `supply_ok` and `enable` are both high in the idle state, `striking` rises at the next edge with `timer_val` = 0. The timer then rises by SLOW_STEP on each edge.
- R3: Striking is made of STRIKE_PASSES ramps. Ramp one runs from 0 up to STR_TOP. Each later ramp reloads `timer_val` to STR_RESTART on the edge after the timer has reached STR_TOP. With SLOW_STEP = 1, `striking` stays high for (STR_TOP+1) + (STRIKE_PASSES-1)*(STR_TOP-STR_RESTART+1) cycles.
- R4: If the lamp has not ignited when the final striking ramp ends, `latched_off` rises and `striking` falls on the same edge.
- R5: Striking ends with a move to normal mode (`running` = 1, `timer_val` = 0) on the first edge at which `open_low` = 0 and `overvolt` = 0. While `overvolt` = 1, striking continues.
- R6: During striking, `short_low` and `ctl_high` have no effect, and `overvolt` only prevents ignition. None of them causes shutdown before the striking budget runs out.
- R7: In normal mode, `open_low` (when `contrast_mode` = 0) or `ctl_high` alone charges the timer by SLOW_STEP per edge. Shutdown follows ceil(NOR_TOP/SLOW_STEP)+1 edges after the fault appears.
- R8: In normal mode, `short_low` (when `contrast_mode` = 0) or `overvolt` charges the timer by FAST_STEP per edge. When a slow fault and a fast fault are present together, the fast rate is used. Shutdown follows ceil(NOR_TOP/FAST_STEP)+1 edges.
- R9: In normal mode, `timer_val` returns to 0 on the first edge with no active fault.
- R10: With `contrast_mode` = 1 in normal mode, `open_low` and `short_low` neither charge the timer nor cause shutdown.
- R11: `overtemp` during striking or normal mode sets `latched_off` on the next edge, with no delay.
- R12: `latched_off` stays high while `supply_ok` and `enable` stay high, whatever the fault inputs do. Dropping either input clears it.
- R13: At most one of `striking`, `running` and `latched_off` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply above start threshold (hysteresis applied upstream) |
| enable | input | 1 | Enable above on level |
| contrast_mode | input | 1 | Enable above upper level; masks open- and short-lamp faults |
| open_low | input | 1 | Open-lamp feedback below its threshold |
| overvolt | input | 1 | Lamp voltage above over-voltage reference |
| short_low | input | 1 | Minimum lamp voltage below short-lamp level |
| ctl_high | input | 1 | Control voltage above high limit |
| overtemp | input | 1 | Die over-temperature |
| striking | output | 1 | Striking phase active |
| running | output | 1 | Normal mode active |
| latched_off | output | 1 | Latched shutdown |
| timer_val | output | TMR_W | Delay timer value |

## Verification
The checker tests the local, cycle-to-cycle rules on every cycle. These are mutual exclusion of the mode flags, the idle state after losing supply or enable, the entry into striking, the exit on ignition, instant thermal trip, the holding of the latch, the timer clear when no fault is active, and the absence of shutdown in contrast mode. Only the bench scenarios can show the long-window behaviours: the exact length of the multi-pass striking budget, the trip delay for each fault class and for mixed faults, and the return to operation after the latch is cleared.

// File: rtl/lps_pkg.sv
package lps_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_STRIKE = 2'd1,
      ST_RUN    = 2'd2,
      ST_TRIP   = 2'd3
   } seq_state_e;
endpackage

// File: rtl/lps_fault_gate.sv
// Folds the comparator flags into the rate requests used in normal mode
// and the ignition qualifier used while striking.
module lps_fault_gate (
   input  logic contrast_mode,
   input  logic open_low,
   input  logic overvolt,
   input  logic short_low,
   input  logic ctl_high,
   output logic slow_fault,
   output logic fast_fault,
   output logic ignite_ok
);
   always_comb begin
      fast_fault = overvolt | (short_low & ~contrast_mode);
      slow_fault = ctl_high | (open_low & ~contrast_mode);
      ignite_ok  = ~open_low & ~overvolt;
   end
endmodule

// File: rtl/lps_delay_timer.sv
// Delay counter with clear, reload to a restart level and two charge rates.
module lps_delay_timer #(
   parameter int TMR_W    = 16,
   parameter int SLOW     = 1,
   parameter int FAST     = 25,
   parameter int RESTART  = 300,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             reload,
   input  logic             inc_slow,
   input  logic             inc_fast,
   output logic [TMR_W-1:0] value
);
   localparam logic [TMR_W:0]   MAXV   = {1'b0, {TMR_W{1'b1}}};
   localparam logic [TMR_W:0]   STEP_S = (TMR_W+1)'(SLOW);
   localparam logic [TMR_W:0]   STEP_F = (TMR_W+1)'(FAST);
   localparam logic [TMR_W-1:0] RELV   = TMR_W'(RESTART);

   logic [TMR_W:0]   step;
   logic [TMR_W:0]   sum;
   logic [TMR_W-1:0] nxt;

   always_comb begin
      if (inc_fast)      step = STEP_F;
      else if (inc_slow) step = STEP_S;
      else               step = '0;
      sum = {1'b0, value} + step;
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb nxt = (sum > MAXV) ? MAXV[TMR_W-1:0] : sum[TMR_W-1:0];
      end else begin : g_wrap
         always_comb nxt = sum[TMR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      value <= '0;
      else if (clr)    value <= '0;
      else if (reload) value <= RELV;
      else             value <= nxt;
   end
endmodule

// File: rtl/lamp_prot_seq.sv
module lamp_prot_seq #(
   parameter int TMR_W         = 16,
   parameter int SLOW_STEP     = 1,
   parameter int FAST_STEP     = 25,
   parameter int STR_TOP       = 3000,
   parameter int STR_RESTART   = 300,
   parameter int NOR_TOP       = 1000,
   parameter int STRIKE_PASSES = 5,
   parameter bit SATURATE      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_ok,
   input  logic             enable,
   input  logic             contrast_mode,
   input  logic             open_low,
   input  logic             overvolt,
   input  logic             short_low,
   input  logic             ctl_high,
   input  logic             overtemp,
   output logic             striking,
   output logic             running,
   output logic             latched_off,
   output logic [TMR_W-1:0] timer_val
);
   import lps_pkg::*;

   localparam int PW = $clog2(STRIKE_PASSES);
   localparam logic [PW-1:0]    LAST_PASS = PW'(STRIKE_PASSES - 1);
   localparam logic [TMR_W-1:0] STR_LIM   = TMR_W'(STR_TOP);
   localparam logic [TMR_W-1:0] NOR_LIM   = TMR_W'(NOR_TOP);

   generate
      if (STRIKE_PASSES < 2) begin : g_bad_passes
         $error("STRIKE_PASSES must be at least 2");
      end
      if (STR_RESTART >= STR_TOP) begin : g_bad_restart
         $error("STR_RESTART must be below STR_TOP");
      end
      if (FAST_STEP < SLOW_STEP || SLOW_STEP < 1) begin : g_bad_rates
         $error("need 1 <= SLOW_STEP <= FAST_STEP");
      end
      if ((longint'(NOR_TOP) + FAST_STEP) >= (64'd1 << TMR_W) ||
          (longint'(STR_TOP) + SLOW_STEP) >= (64'd1 << TMR_W)) begin : g_bad_width
         $error("TMR_W too narrow for the limits");
      end
   endgenerate

   seq_state_e    st, st_nxt;
   logic [PW-1:0] pass_cnt;
   logic          active;
   logic          slow_fault, fast_fault, ignite_ok;
   logic          t_clr, t_rel, t_slow, t_fast;
   logic          pass_inc, pass_clr;
   logic          strike_top, run_top;

   lps_fault_gate u_gate (
      .contrast_mode (contrast_mode),
      .open_low      (open_low),
      .overvolt      (overvolt),
      .short_low     (short_low),
      .ctl_high      (ctl_high),
      .slow_fault    (slow_fault),
      .fast_fault    (fast_fault),
      .ignite_ok     (ignite_ok)
   );

   lps_delay_timer #(
      .TMR_W    (TMR_W),
      .SLOW     (SLOW_STEP),
      .FAST     (FAST_STEP),
      .RESTART  (STR_RESTART),
      .SATURATE (SATURATE)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (t_clr),
      .reload   (t_rel),
      .inc_slow (t_slow),
      .inc_fast (t_fast),
      .value    (timer_val)
   );

   always_comb begin
      active     = supply_ok & enable;
      strike_top = (timer_val >= STR_LIM);
      run_top    = (timer_val >= NOR_LIM);
   end

   always_comb begin
      st_nxt   = st;
      t_clr    = 1'b0;
      t_rel    = 1'b0;
      t_slow   = 1'b0;
      t_fast   = 1'b0;
      pass_inc = 1'b0;
      pass_clr = 1'b0;
      if (!active) begin
         st_nxt   = ST_IDLE;
         t_clr    = 1'b1;
         pass_clr = 1'b1;
      end else begin
         unique case (st)
            ST_IDLE: begin
               st_nxt   = ST_STRIKE;
               t_clr    = 1'b1;
               pass_clr = 1'b1;
            end
            ST_STRIKE: begin
               if (overtemp) begin
                  st_nxt = ST_TRIP;
               end else if (ignite_ok) begin
                  st_nxt = ST_RUN;
                  t_clr  = 1'b1;
               end else if (strike_top) begin
                  if (pass_cnt == LAST_PASS) begin
                     st_nxt = ST_TRIP;
                  end else begin
                     pass_inc = 1'b1;
                     t_rel    = 1'b1;
                  end
               end else begin
                  t_slow = 1'b1;
               end
            end
            ST_RUN: begin
               if (overtemp) begin
                  st_nxt = ST_TRIP;
               end else if (fast_fault || slow_fault) begin
                  if (run_top) begin
                     st_nxt = ST_TRIP;
                  end else begin
                     t_fast = fast_fault;
                     t_slow = ~fast_fault;
                  end
               end else begin
                  t_clr = 1'b1;
               end
            end
            ST_TRIP: begin
               st_nxt = ST_TRIP;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         pass_cnt <= '0;
      end else begin
         st <= st_nxt;
         if (pass_clr)      pass_cnt <= '0;
         else if (pass_inc) pass_cnt <= pass_cnt + 1'b1;
      end
   end

   always_comb begin
      striking    = (st == ST_STRIKE);
      running     = (st == ST_RUN);
      latched_off = (st == ST_TRIP);
   end
endmodule

// File: rtl/lamp_prot_seq_chk.sv
module lamp_prot_seq_chk #(
   parameter int TMR_W   = 16,
   parameter int STR_TOP = 3000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             supply_ok,
   input logic             enable,
   input logic             contrast_mode,
   input logic             open_low,
   input logic             overvolt,
   input logic             short_low,
   input logic             ctl_high,
   input logic             overtemp,
   input logic             striking,
   input logic             running,
   input logic             latched_off,
   input logic [TMR_W-1:0] timer_val
);
   logic act;
   logic quiet;
   assign act   = supply_ok & enable;
   assign quiet = ~overvolt & ~ctl_high & (contrast_mode | (~open_low & ~short_low));

   a_r13_onehot_modes: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({striking, running, latched_off}));

   a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> (!striking && !running && !latched_off && timer_val == '0));

   a_r2_strike_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !striking && !running && !latched_off) |=> (striking && timer_val == '0));

   a_r5_ignite_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (striking && act && !overtemp && !open_low && !overvolt) |=> (running && timer_val == '0));

   a_r6_no_early_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (striking && act && !overtemp && timer_val < TMR_W'(STR_TOP)) |=> !latched_off);

   a_r9_timer_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (running && act && !overtemp && quiet) |=> (timer_val == '0));

   a_r10_contrast_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (running && act && contrast_mode && !overvolt && !ctl_high && !overtemp) |=> !latched_off);

   a_r11_thermal_trip: assert property (@(posedge clk) disable iff (!rst_n)
      ((striking || running) && act && overtemp) |=> latched_off);

   a_r12_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (latched_off && act) |=> latched_off);
endmodule

bind lamp_prot_seq lamp_prot_seq_chk #(
   .TMR_W   (TMR_W),
   .STR_TOP (STR_TOP)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .supply_ok     (supply_ok),
   .enable        (enable),
   .contrast_mode (contrast_mode),
   .open_low      (open_low),
   .overvolt      (overvolt),
   .short_low     (short_low),
   .ctl_high      (ctl_high),
   .overtemp      (overtemp),
   .striking      (striking),
   .running       (running),
   .latched_off   (latched_off),
   .timer_val     (timer_val)
);

// File: tb/test_lamp_prot_seq.sv
`timescale 1ns/1ps
module test_lamp_prot_seq;
   localparam int W      = 8;
   localparam int SLOW   = 1;
   localparam int FAST   = 25;
   localparam int STOP   = 20;
   localparam int SRST   = 2;
   localparam int NTOP   = 50;
   localparam int PASSES = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 0, enable = 0, contrast_mode = 0;
   logic open_low = 0, overvolt = 0, short_low = 0, ctl_high = 0, overtemp = 0;
   logic striking, running, latched_off;
   logic [W-1:0] timer_val;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   lamp_prot_seq #(
      .TMR_W(W), .SLOW_STEP(SLOW), .FAST_STEP(FAST), .STR_TOP(STOP),
      .STR_RESTART(SRST), .NOR_TOP(NTOP), .STRIKE_PASSES(PASSES)
   ) i_lamp_prot_seq (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
      .contrast_mode(contrast_mode), .open_low(open_low), .overvolt(overvolt),
      .short_low(short_low), .ctl_high(ctl_high), .overtemp(overtemp),
      .striking(striking), .running(running), .latched_off(latched_off),
      .timer_val(timer_val)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int mode_code();
      return {29'd0, latched_off, running, striking};
   endfunction

   task automatic clear_faults();
      open_low = 0; overvolt = 0; short_low = 0; ctl_high = 0; overtemp = 0;
      contrast_mode = 0;
   endtask

   // Drop enable, then restart with clean feedback so the lamp ignites at once.
   task automatic go_normal();
      clear_faults();
      enable = 0;
      repeat (2) @(negedge clk);
      enable = 1;
      repeat (2) @(negedge clk);
   endtask

   task automatic count_to_trip(output int n);
      n = 0;
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk);
         n++;
         if (latched_off) break;
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      int exp_strike, exp_slow, exp_fast;
      exp_strike = (STOP + 1) + (PASSES - 1) * (STOP - SRST + 1);
      exp_slow   = (NTOP + SLOW - 1) / SLOW + 1;
      exp_fast   = (NTOP + FAST - 1) / FAST + 1;

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: idle after reset
      chk("R1 modes after reset", mode_code(), 0);
      chk("R1 timer after reset", int'(timer_val), 0);

      supply_ok = 1; open_low = 1; overvolt = 1; short_low = 1; ctl_high = 1;
      repeat (3) @(negedge clk);
      chk("R1 enable low keeps idle", mode_code(), 0);

      // R2: striking entry, then slow ramp
      enable = 1;
      @(negedge clk);
      chk("R2 striking entered", mode_code(), 1);
      chk("R2 timer starts at zero", int'(timer_val), 0);
      repeat (5) @(negedge clk);
      chk("R2 slow ramp", int'(timer_val), 5 * SLOW);

      // R3/R4/R6: full striking budget with short and ctl_high held
      go_normal();
      enable = 0;
      @(negedge clk);
      open_low = 1; short_low = 1; ctl_high = 1; overvolt = 1;
      enable = 1;
      n = 0;
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk);
         if (striking) n++;
         if (n == STOP + 2 && striking) chk("R3 reload to restart level", int'(timer_val), SRST);
         if (latched_off) break;
      end
      chk("R3 striking length", n, exp_strike);
      chk("R4 shutdown after strike expiry", mode_code(), 4);
      chk("R6 no early trip while striking", n >= exp_strike ? 1 : 0, 1);

      // R12: latch holds with faults removed
      clear_faults();
      repeat (10) @(negedge clk);
      chk("R12 latch holds", int'(latched_off), 1);
      enable = 0;
      @(negedge clk);
      chk("R12 enable low clears", mode_code(), 0);

      // R5: overvolt blocks ignition, then exit
      open_low = 1;
      enable = 1;
      @(negedge clk);
      open_low = 0; overvolt = 1;
      repeat (4) @(negedge clk);
      chk("R5 overvolt blocks ignition", mode_code(), 1);
      overvolt = 0;
      @(negedge clk);
      chk("R5 ignition to normal", mode_code(), 2);
      chk("R5 timer cleared at ignition", int'(timer_val), 0);

      // R9: timer accumulates then clears
      open_low = 1;
      repeat (10) @(negedge clk);
      chk("R7 slow accumulation", int'(timer_val), 10 * SLOW);
      open_low = 0;
      @(negedge clk);
      chk("R9 timer clears without fault", int'(timer_val), 0);
      chk("R9 still normal", mode_code(), 2);

      // R7/R8: sweep of fault classes in normal mode
      for (int f = 0; f < 6; f++) begin
         go_normal();
         chk("R5 normal before sweep", mode_code(), 2);
         case (f)
            0: open_low = 1;
            1: ctl_high = 1;
            2: short_low = 1;
            3: overvolt = 1;
            4: begin open_low = 1; short_low = 1; end
            default: begin ctl_high = 1; overvolt = 1; end
         endcase
         count_to_trip(n);
         if (f < 2) chk("R7 slow trip delay", n, exp_slow);
         else       chk("R8 fast trip delay", n, exp_fast);
      end

      // R10: contrast mode masks open and short lamp
      go_normal();
      contrast_mode = 1; open_low = 1; short_low = 1;
      repeat (3 * NTOP) @(negedge clk);
      chk("R10 no shutdown in contrast mode", mode_code(), 2);
      chk("R10 timer stays zero", int'(timer_val), 0);
      overvolt = 1;
      count_to_trip(n);
      chk("R10 overvolt still trips in contrast mode", n, exp_fast);

      // R11: thermal immediate, normal and striking
      go_normal();
      overtemp = 1;
      count_to_trip(n);
      chk("R11 thermal trip in normal", n, 1);
      clear_faults();
      enable = 0;
      @(negedge clk);
      open_low = 1; enable = 1;
      @(negedge clk);
      chk("R2 restart after clear", mode_code(), 1);
      overtemp = 1;
      count_to_trip(n);
      chk("R11 thermal trip in striking", n, 1);

      // R12: supply drop clears latch
      supply_ok = 0;
      @(negedge clk);
      chk("R12 supply drop clears", mode_code(), 0);
      chk("R1 timer idle after supply drop", int'(timer_val), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule